// File: doc/BRIEF.md
# PC Card Socket Status Change Interrupt Controller

This block watches the input pins of one or two PC card sockets and turns pin activity into sticky status change flags and a single interrupt line. Each socket brings in two voltage sense pins, a write protect pin, two card detect pins, two battery voltage detect pins and a ready pin. Every pin passes through a two-flop synchronizer. The block then derives change events from the pins, and it derives four extra event sources from the ready line: low level, high level, rising edge and falling edge.

Software sees three 32-bit registers through a simple select/write/read port. The first shows the synchronized pin levels. The second holds the status change flags, and a bit in it is cleared by writing a one to it. The third is an enable mask. The interrupt output goes high when any flag is set and enabled. Both sockets share each register. Socket A (slot 0) owns the upper half and socket B (slot 1) owns the lower half with the same layout. A card detect change counts only when both detect pins agree once the change has happened.

Top module: `pc_card_status_irq`

## Requirements
- R1: While reset is high, and in the cycle after it, the status register, the enable register and `irq_o` are zero, and the pin view reads zero.
- R2: The pin view (select 0) shows the synchronized pins two clocks after a pin change. For slot s, bits [31-16s : 24-16s] hold, from high to low, VS1, VS2, WP, CD2, CD1, BVD2, BVD1, RDY, which is input byte s bits 7..0. All other bits read zero.
- R3: A change on VS1, VS2, WP, BVD2, BVD1 or RDY sets the status bit (select 1) at the same position as that pin in the pin view. The bit stays set until it is cleared.
- R4: A status bit for CD2 (bit 28-16s) or CD1 (bit 27-16s) is set only when that pin changes and CD2 equals CD1 after the change. A change that leaves the two pins different sets nothing.
- R5: A rising edge of RDY sets bit 21-16s and a falling edge sets bit 20-16s. Both are sticky.
- R6: Bit 23-16s is a level source. It reads one while RDY is low and zero while RDY is high, and writes do not affect it. Bit 22-16s is set in every cycle in which RDY is high, so a clear only takes effect once RDY is low. A set in the same cycle as a clear wins.
- R7: Writing the status register clears each bit written as one. Bits written as zero keep their value.
- R8: The enable register (select 2) is read/write, but only bits [31:20] and [15:4] are implemented. The other bits of enable and status read zero, and select 3 reads zero.
- R9: `irq_o` is a register holding the OR of (status AND enable) from the previous cycle.
- R10: The pin levels present when reset is released create no change or edge events. Only level sources reflect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_pins_i | input | 8*NUM_SLOTS | Raw socket pins. Byte s is slot s: VS1, VS2, WP, CD2, CD1, BVD2, BVD1, RDY from bit 7 to bit 0 |
| reg_sel_i | input | 2 | Register select: 0 pin view, 1 status, 2 enable, 3 none |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data of the selected register |
| irq_o | output | 1 | Registered status change interrupt |

## Verification
The bench releases reset with the ready pin already high. A design that compared against reset-state flops would then report a phantom rising edge. Clearing the ready level bits while the level still holds must leave them set, and writing zeros must leave every flag alone. A design with the wrong clear priority or masking would lose events or clear bits it should keep. Card detect is moved one pin at a time and then both together. Suppression while the pins disagree and setting both flags on a joint change catch a qualifier that is missing or one that is reversed. Slot B events, the masked enable bits and the interrupt rising and falling with enable and clear expose errors in field placement and in the interrupt path.

// File: rtl/pcsc_pkg.sv
package pcsc_pkg;

    localparam int REG_W     = 32;
    localparam int FIELD_W   = 16;
    localparam int PIN_W     = 8;
    localparam int MAX_SLOTS = REG_W / FIELD_W;

    // packed: first member is the most significant bit
    typedef struct packed {
        logic vs1;
        logic vs2;
        logic wp;
        logic cd2;
        logic cd1;
        logic bvd2;
        logic bvd1;
        logic rdy;
    } card_pins_t;

    typedef struct packed {
        card_pins_t chg;
        logic       rdy_low;
        logic       rdy_high;
        logic       rdy_rise;
        logic       rdy_fall;
        logic [3:0] rsvd;
    } slot_field_t;

    typedef enum logic [1:0] {
        SEL_PINS   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam logic [FIELD_W-1:0] FIELD_IMPL  = 16'hFFF0;
    localparam logic [FIELD_W-1:0] FIELD_LEVEL = 16'h0080;

    // Put a 16-bit slot field into its place in the shared register.
    function automatic logic [REG_W-1:0] place_field(input logic [FIELD_W-1:0] f, input int slot);
        logic [REG_W-1:0] t;
        t = {f, {(REG_W-FIELD_W){1'b0}}};
        return t >> (slot * FIELD_W);
    endfunction

    function automatic logic [REG_W-1:0] slots_mask(input logic [FIELD_W-1:0] f, input int nslots);
        logic [REG_W-1:0] m;
        m = '0;
        for (int s = 0; s < nslots; s++) m |= place_field(f, s);
        return m;
    endfunction

endpackage

// File: rtl/pcsc_sync.sv
module pcsc_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         vld_o
);
    logic [W-1:0]      stg [STAGES];
    logic [STAGES-1:0] vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            vld <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            vld <= {vld[STAGES-2:0], 1'b1};
        end
    end

    assign q_o   = stg[STAGES-1];
    assign vld_o = vld[STAGES-1];
endmodule

// File: rtl/pcsc_slot_events.sv
module pcsc_slot_events
    import pcsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  card_pins_t  pins_i,
    input  logic        pins_vld_i,
    output slot_field_t set_o,
    output logic        rdy_low_o
);
    card_pins_t prev_q;
    logic       prev_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= '0;
            prev_vld_q <= 1'b0;
        end else begin
            prev_q     <= pins_i;
            prev_vld_q <= pins_vld_i;
        end
    end

    card_pins_t diff;
    logic       cd_agree;

    always_comb begin
        diff     = prev_vld_q ? card_pins_t'(pins_i ^ prev_q) : '0;
        cd_agree = (pins_i.cd2 == pins_i.cd1);
        set_o          = '0;
        set_o.chg      = diff;
        set_o.chg.cd2  = diff.cd2 & cd_agree;
        set_o.chg.cd1  = diff.cd1 & cd_agree;
        set_o.rdy_high = pins_vld_i & pins_i.rdy;
        set_o.rdy_rise = diff.rdy & pins_i.rdy;
        set_o.rdy_fall = diff.rdy & ~pins_i.rdy;
        rdy_low_o      = pins_vld_i & ~pins_i.rdy;
    end
endmodule

// File: rtl/pcsc_regs.sv
module pcsc_regs
    import pcsc_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_i,
    input  logic [REG_W-1:0] level_i,
    input  logic             wr_i,
    input  reg_sel_e         sel_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] enable_o,
    output logic             irq_o
);
    localparam logic [REG_W-1:0] IMPL   = slots_mask(FIELD_IMPL, NUM_SLOTS);
    localparam logic [REG_W-1:0] LEVEL  = slots_mask(FIELD_LEVEL, NUM_SLOTS);
    localparam logic [REG_W-1:0] STICKY = IMPL & ~LEVEL;

    logic [REG_W-1:0] status_q, enable_q, clr, status_d;
    logic             irq_q;

    always_comb begin
        clr      = (wr_i && sel_i == SEL_STATUS) ? wdata_i : '0;
        status_d = (((status_q & ~clr) | set_i) & STICKY) | (level_i & LEVEL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            if (wr_i && sel_i == SEL_ENABLE) enable_q <= wdata_i & IMPL;
            irq_q    <= |(status_q & enable_q);
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/pc_card_status_irq.sv
module pc_card_status_irq
    import pcsc_pkg::*;
#(
    parameter int NUM_SLOTS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SLOTS*8-1:0]   slot_pins_i,
    input  logic [1:0]               reg_sel_i,
    input  logic                     reg_wr_i,
    input  logic [31:0]              reg_wdata_i,
    output logic [31:0]              reg_rdata_o,
    output logic                     irq_o
);
    localparam int PINS_W = NUM_SLOTS * PIN_W;

    logic [PINS_W-1:0] pins_sync;
    logic              pins_vld;

    pcsc_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(slot_pins_i), .q_o(pins_sync), .vld_o(pins_vld)
    );

    card_pins_t  slot_pins [NUM_SLOTS];
    slot_field_t slot_set  [NUM_SLOTS];
    logic        slot_low  [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_pins[s] = card_pins_t'(pins_sync[s*PIN_W +: PIN_W]);
        pcsc_slot_events u_ev (
            .clk(clk), .rst(rst),
            .pins_i(slot_pins[s]), .pins_vld_i(pins_vld),
            .set_o(slot_set[s]), .rdy_low_o(slot_low[s])
        );
    end

    logic [REG_W-1:0] set_all, level_all, pin_view;

    always_comb begin
        set_all   = '0;
        level_all = '0;
        pin_view  = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            set_all   |= place_field(slot_set[s], s);
            level_all |= place_field(FIELD_LEVEL & {FIELD_W{slot_low[s]}}, s);
            pin_view  |= place_field({slot_pins[s], 8'h00}, s);
        end
    end

    reg_sel_e         sel;
    logic [REG_W-1:0] status_q, enable_q;

    assign sel = reg_sel_e'(reg_sel_i);

    pcsc_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
        .clk(clk), .rst(rst),
        .set_i(set_all), .level_i(level_all),
        .wr_i(reg_wr_i), .sel_i(sel), .wdata_i(reg_wdata_i),
        .status_o(status_q), .enable_o(enable_q), .irq_o(irq_o)
    );

    always_comb begin
        case (sel)
            SEL_PINS:   reg_rdata_o = pin_view;
            SEL_STATUS: reg_rdata_o = status_q;
            SEL_ENABLE: reg_rdata_o = enable_q;
            default:    reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pcsc_checker.sv
module pcsc_checker
    import pcsc_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  reg_sel_i,
    input logic        reg_wr_i,
    input logic [31:0] reg_wdata_i,
    input logic [31:0] pin_view,
    input logic [31:0] status_q,
    input logic [31:0] enable_q,
    input logic        irq_o
);
    localparam logic [31:0] IMPL   = slots_mask(FIELD_IMPL, NUM_SLOTS);
    localparam logic [31:0] STICKY = IMPL & ~slots_mask(FIELD_LEVEL, NUM_SLOTS);

    logic [31:0] clr_mask;
    assign clr_mask = (reg_wr_i && reg_sel_i == 2'd1) ? reg_wdata_i : 32'h0;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (status_q == 32'h0 && enable_q == 32'h0 && !irq_o));

    // R9
    a_r9_irq_registered: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == (|($past(status_q) & $past(enable_q)))));

    // R8
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        ((status_q | enable_q) & ~IMPL) == 32'h0);

    // R7
    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status_q) & ~$past(clr_mask)) & STICKY & ~status_q) == 32'h0));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
        // R6
        a_r6_high_level: assert property (@(posedge clk) disable iff (rst)
            pin_view[24-16*s] |=> (status_q[22-16*s] && !status_q[23-16*s]));
    end
endmodule

bind pc_card_status_irq pcsc_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk(clk), .rst(rst),
    .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .pin_view(pin_view), .status_q(status_q), .enable_q(enable_q), .irq_o(irq_o)
);

// File: tb/pc_card_status_irq_tb.sv
module pc_card_status_irq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] slot_pins_i = 16'h0001;
    logic [1:0]  reg_sel_i = 2'd0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = 32'h0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int          q_kind [$];
    logic [31:0] q_exp  [$];
    string       q_tag  [$];
    event        ev_chk;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_card_status_irq u_dut (
        .clk(clk), .rst(rst), .slot_pins_i(slot_pins_i),
        .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(ev_chk);
            #1;
            while (q_kind.size() > 0) begin
                int          k;
                logic [31:0] e, a;
                string       t;
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                a = (k == 1) ? {31'h0, irq_o} : reg_rdata_o;
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %08h expected %08h", t, a, e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel_i = sel; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic exp_reg(input logic [1:0] sel, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_sel_i = sel;
        q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
        -> ev_chk;
        #2;
    endtask

    task automatic exp_irq(input logic e, input string t);
        @(negedge clk);
        q_kind.push_back(1); q_exp.push_back({31'h0, e}); q_tag.push_back(t);
        -> ev_chk;
        #2;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        exp_reg(2'd1, 32'h0, "R1 status in reset");
        exp_reg(2'd2, 32'h0, "R1 enable in reset");
        exp_reg(2'd0, 32'h0, "R1 pins in reset");
        exp_irq(1'b0, "R1 irq in reset");
        rst = 1'b0;
        settle();
        // slot A ready high, slot B ready low at release
        exp_reg(2'd1, 32'h0040_0080, "R10 no events from release levels");
        exp_reg(2'd0, 32'h0100_0000, "R2 pin view");
        exp_irq(1'b0, "R9 no irq when disabled");

        wr(2'd1, 32'hFFFF_FFFF); settle();
        exp_reg(2'd1, 32'h0040_0080, "R6 level bits survive clear");

        slot_pins_i[7:0] = 8'h00; settle();
        exp_reg(2'd1, 32'h01D0_0080, "R5 falling edge, R3 rdy change");
        wr(2'd1, 32'h0); settle();
        exp_reg(2'd1, 32'h01D0_0080, "R7 zero write keeps bits");
        wr(2'd1, 32'h0040_0000); settle();
        exp_reg(2'd1, 32'h0190_0080, "R6 high cleared once low");

        slot_pins_i[7:0] = 8'h01; settle();
        exp_reg(2'd1, 32'h0170_0080, "R5 rising edge");
        wr(2'd1, 32'hFFFF_FFFF); settle();
        exp_reg(2'd1, 32'h0040_0080, "R7 clear all sticky");

        slot_pins_i[7:0] = 8'h09; settle();
        exp_reg(2'd1, 32'h0040_0080, "R4 disagree suppressed");
        exp_reg(2'd0, 32'h0900_0000, "R2 pin view cd1");
        slot_pins_i[7:0] = 8'h19; settle();
        exp_reg(2'd1, 32'h1040_0080, "R4 agree sets cd2");

        wr(2'd2, 32'h1000_0000); settle();
        exp_irq(1'b1, "R9 irq on enabled flag");
        wr(2'd1, 32'h1000_0000); settle();
        exp_irq(1'b0, "R9 irq drops after clear");
        exp_reg(2'd1, 32'h0040_0080, "R7 single bit clear");

        slot_pins_i[7:0] = 8'h01; settle();
        exp_reg(2'd1, 32'h1840_0080, "R4 joint change sets both");
        exp_irq(1'b1, "R9 irq on cd event");
        wr(2'd1, 32'h1800_0000); settle();

        wr(2'd2, 32'hFFFF_FFFF);
        exp_reg(2'd2, 32'hFFF0_FFF0, "R8 enable reserved bits");
        settle();
        exp_irq(1'b1, "R9 irq from level bits");
        wr(2'd2, 32'h0); settle();
        exp_irq(1'b0, "R9 irq off when disabled");
        exp_reg(2'd3, 32'h0, "R8 unused select");

        slot_pins_i[15:8] = 8'h20; settle();
        exp_reg(2'd1, 32'h0040_2080, "R3 slot B write protect");
        slot_pins_i[7:0] = 8'h81; settle();
        exp_reg(2'd1, 32'h8040_2080, "R3 slot A voltage sense");
        exp_reg(2'd0, 32'h8100_2000, "R2 both slots pin view");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule